// File: doc/BRIEF.md
# I2C Sixteen-Pin GPIO Expander

This block is an I2C target that gives a bus master control of sixteen general-purpose pins, grouped as two 8-bit ports. Each port has four registers: a live input view, an output latch, a per-bit polarity mask and a per-bit direction mask. A master writes a command byte that sets an internal register pointer. It then streams data bytes into the selected register pair, or issues a repeated START and reads the pair back.

The serial lines and the pins are each resynchronised and passed through a three-sample majority filter before any logic uses them. The 7-bit target address is `0100` followed by the three strap inputs, so eight of these blocks can share one bus. An active-low interrupt reports that a pin set as an input has moved away from the value captured the last time its port's input register was read.

Top module: `gpio_expander_i2c`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), the output latches read 0xFF, the polarity masks read 0x00, the direction masks read 0xFF, `int_n` is high and `sda_oe` is low.
- R2: The block acknowledges only the address {0100, strap_i[2:0]}. Any other address gets no acknowledge and changes no register.
- R3: The first byte after a write address is a command whose low three bits set the pointer. Codes are 0/1 input, 2/3 output, 4/5 polarity and 6/7 direction, where even codes are port 0 (pins 7:0) and odd codes are port 1 (pins 15:8). Each later data byte goes to the pointed register, and the pointer's bit 0 then toggles.
- R4: A direction bit of 1 makes its pin an input (`pin_oe`=0). A direction bit of 0 makes it an output that drives the output latch bit on `pin_o` with `pin_oe`=1.
- R5: A read returns the pointed register first, and each further byte toggles pointer bit 0. A read that follows a command-only write uses that command's pointer.
- R6: An input register reads the filtered pin level XOR its polarity mask, for output pins as well as input pins.
- R7: Data bytes written to codes 0 and 1 change no register.
- R8: `int_n` goes low when a pin set as an input differs from the level captured at the last read of its port's input register. Pins set as outputs never cause it.
- R9: The interrupt contribution of a port clears when that port's input register is read, or when its input pins return to the captured level. Reading the other port does not clear it.
- R10: The block pulls SDA low to acknowledge a matching address and each written byte. It releases SDA after the master's NACK at the end of a read.
- R11: A disturbance on SCL lasting a single system-clock cycle does not clock a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Low three bits of the target address |
| pin_i | input | 16 | Sensed pin levels |
| pin_o | output | 16 | Pin output values |
| pin_oe | output | 16 | Per-pin output enable |
| int_n | output | 1 | Active-low change interrupt |

## Verification
Assertions placed in the design check the following on every cycle:
- SDA is driven only in acknowledge or transmit states.
- A START always leads into address reception.
- SDA is released after a master NACK.
- A write to an input register leaves every stored register unchanged.
- The interrupt stays quiet while all pins are outputs.

Some behaviour can only be shown by the bench's bus scenarios:
- The command-pointer semantics and pair toggling on reads and writes.
- The XOR view of the pins.
- Per-port interrupt clearing, and clearing when a pin reverts.
- Address matching under two strap settings.
- Rejection of a one-cycle SCL glitch.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam logic [3:0] ADDR_PREFIX = 4'b0100;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_RX, S_WACK, S_TX, S_MACK
    } tgt_st_e;

    typedef enum logic [1:0] {
        K_IN  = 2'd0,
        K_OUT = 2'd1,
        K_POL = 2'd2,
        K_CFG = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/gpx_glitch_filter.sv
module gpx_glitch_filter #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] clean_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] h0;
        logic [W-1:0] h1;
        logic [W-1:0] h2;
        logic [W-1:0] o;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d    = q;
        d.s1 = raw_i;
        d.s2 = q.s1;
        d.h0 = q.s2;
        d.h1 = q.h0;
        d.h2 = q.h1;
        d.o  = (q.h0 & q.h1) | (q.h0 & q.h2) | (q.h1 & q.h2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= {6{RST_VAL}};
        else        q <= d;
    end

    assign clean_o = q.o;
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
    import gpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic [7:0] rd_data_i,
    output logic [2:0] ptr_o,
    output logic       wr_stb_o,
    output logic [7:0] wr_data_o,
    output logic       rd_stb_o,
    output logic       sda_oe_o
);
    localparam logic [3:0] BITS = 4'd8;

    typedef struct packed {
        tgt_st_e    st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] tx;
        logic [2:0] ptr;
        logic       rw;
        logic       first;
        logic       oe;
        logic       mack;
        logic       scl_p;
        logic       sda_p;
    } tgt_t;

    tgt_t q, d;
    logic scl_rise, scl_fall, start_evt, stop_evt, load;

    assign scl_rise  = scl_i & ~q.scl_p;
    assign scl_fall  = ~scl_i & q.scl_p;
    assign start_evt = scl_i & q.scl_p & ~sda_i & q.sda_p;
    assign stop_evt  = scl_i & q.scl_p & sda_i & ~q.sda_p;

    always_comb begin
        d        = q;
        wr_stb_o = 1'b0;
        rd_stb_o = 1'b0;
        load     = 1'b0;
        d.scl_p  = scl_i;
        d.sda_p  = sda_i;
        if (start_evt) begin
            d.st  = S_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_evt) begin
            d.st = S_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                S_ADDR, S_RX: begin
                    if (scl_rise && q.cnt != BITS) begin
                        d.sh  = {q.sh[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BITS) begin
                        if (q.st == S_ADDR) begin
                            if (q.sh[7:1] == {ADDR_PREFIX, strap_i}) begin
                                d.st = S_AACK;
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                            end else begin
                                d.st = S_IDLE;
                            end
                        end else begin
                            d.st = S_WACK;
                            d.oe = 1'b1;
                            if (q.first) begin
                                d.ptr   = q.sh[2:0];
                                d.first = 1'b0;
                            end else begin
                                wr_stb_o = 1'b1;
                                d.ptr    = {q.ptr[2:1], ~q.ptr[0]};
                            end
                        end
                    end
                end
                S_AACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            load = 1'b1;
                        end else begin
                            d.st    = S_RX;
                            d.cnt   = '0;
                            d.first = 1'b1;
                            d.oe    = 1'b0;
                        end
                    end
                end
                S_WACK: begin
                    if (scl_fall) begin
                        d.st  = S_RX;
                        d.cnt = '0;
                        d.oe  = 1'b0;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == BITS - 4'd1) begin
                            d.st = S_MACK;
                            d.oe = 1'b0;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.oe  = ~q.tx[6];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) d.mack = ~sda_i;
                    if (scl_fall) begin
                        if (q.mack) load = 1'b1;
                        else        d.st = S_IDLE;
                    end
                end
                default: ;
            endcase
            if (load) begin
                d.st     = S_TX;
                d.cnt    = '0;
                d.tx     = rd_data_i;
                d.oe     = ~rd_data_i[7];
                rd_stb_o = 1'b1;
                d.ptr    = {q.ptr[2:1], ~q.ptr[0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ptr_o     = q.ptr;
    assign wr_data_o = q.sh;
    assign sda_oe_o  = q.oe;

    // R10
    oe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.st inside {S_AACK, S_WACK, S_TX}));

    // R2
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (q.st == S_ADDR));

    // R10
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_MACK && scl_fall && !q.mack && !start_evt && !stop_evt) |=> (!q.oe && q.st == S_IDLE));
endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
    import gpx_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int NPORT  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PORT_W*NPORT-1:0] pin_lvl_i,
    input  logic [2:0]              sel_i,
    input  logic                    wr_stb_i,
    input  logic [PORT_W-1:0]       wr_data_i,
    input  logic                    rd_stb_i,
    output logic [PORT_W-1:0]       rd_data_o,
    output logic [PORT_W*NPORT-1:0] pin_o,
    output logic [PORT_W*NPORT-1:0] pin_oe,
    output logic                    int_n
);
    localparam int PIN_W = PORT_W * NPORT;

    typedef logic [NPORT-1:0][PORT_W-1:0] bank_t;

    typedef struct packed {
        bank_t outr;
        bank_t pol;
        bank_t cfg;
        bank_t snap;
        logic  irq;
    } regs_t;

    localparam regs_t RST = '{outr: '1, pol: '0, cfg: '1, snap: '0, irq: 1'b0};

    regs_t     q, d;
    bank_t     lvl;
    reg_kind_e kind;
    logic      port;
    logic [PIN_W-1:0] diff;

    assign lvl  = pin_lvl_i;
    assign kind = reg_kind_e'(sel_i[2:1]);
    assign port = sel_i[0];

    always_comb begin
        d = q;
        unique case (kind)
            K_IN:    rd_data_o = lvl[port] ^ q.pol[port];
            K_OUT:   rd_data_o = q.outr[port];
            K_POL:   rd_data_o = q.pol[port];
            default: rd_data_o = q.cfg[port];
        endcase
        if (wr_stb_i) begin
            unique case (kind)
                K_OUT:   d.outr[port] = wr_data_i;
                K_POL:   d.pol[port]  = wr_data_i;
                K_CFG:   d.cfg[port]  = wr_data_i;
                default: ;
            endcase
        end
        if (rd_stb_i && kind == K_IN) d.snap[port] = lvl[port];
        diff  = (PIN_W'(lvl) ^ PIN_W'(d.snap)) & PIN_W'(d.cfg);
        d.irq = |diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign pin_o  = PIN_W'(q.outr);
    assign pin_oe = ~PIN_W'(q.cfg);
    assign int_n  = ~q.irq;

    // R7
    in_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && kind == K_IN) |=> ($stable(q.outr) && $stable(q.pol) && $stable(q.cfg)));

    // R8
    out_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cfg == '0) |=> !q.irq);
endmodule

// File: rtl/gpio_expander_i2c.sv
module gpio_expander_i2c #(
    parameter int PORT_W = 8,
    parameter int NPORT  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    input  logic [2:0]              strap_i,
    input  logic [PORT_W*NPORT-1:0] pin_i,
    output logic [PORT_W*NPORT-1:0] pin_o,
    output logic [PORT_W*NPORT-1:0] pin_oe,
    output logic                    int_n
);
    localparam int PIN_W = PORT_W * NPORT;

    logic [1:0]        bus_f;
    logic [PIN_W-1:0]  pin_f;
    logic [2:0]        ptr;
    logic              wr_stb, rd_stb;
    logic [7:0]        wr_data, rd_data;

    gpx_glitch_filter #(.W(2), .RST_VAL(2'b11)) u_bus_flt (
        .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}), .clean_o(bus_f)
    );

    gpx_glitch_filter #(.W(PIN_W), .RST_VAL('0)) u_pin_flt (
        .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .clean_o(pin_f)
    );

    gpx_i2c_target u_tgt (
        .clk(clk), .rst_n(rst_n),
        .scl_i(bus_f[1]), .sda_i(bus_f[0]), .strap_i(strap_i),
        .rd_data_i(rd_data), .ptr_o(ptr),
        .wr_stb_o(wr_stb), .wr_data_o(wr_data),
        .rd_stb_o(rd_stb), .sda_oe_o(sda_oe)
    );

    gpx_port_regs #(.PORT_W(PORT_W), .NPORT(NPORT)) u_regs (
        .clk(clk), .rst_n(rst_n), .pin_lvl_i(pin_f),
        .sel_i(ptr), .wr_stb_i(wr_stb), .wr_data_i(wr_data),
        .rd_stb_i(rd_stb), .rd_data_o(rd_data),
        .pin_o(pin_o), .pin_oe(pin_oe), .int_n(int_n)
    );
endmodule

// File: tb/sim_gpio_expander_i2c.sv
module sim_gpio_expander_i2c;
    localparam int H = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic        sda_line;
    logic [2:0]  strap = 3'b101;
    logic [15:0] pin_i = 16'h0000;
    logic [15:0] pin_o, pin_oe;
    logic        int_n;
    logic [6:0]  cur_addr = 7'h25;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    typedef struct { logic [7:0] v; string req; } item_t;
    item_t      exp_q[$];
    logic [7:0] act_q[$];

    always #10 clk = ~clk;
    assign sda_line = ~(m_low | sda_oe);

    gpio_expander_i2c u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe), .int_n(int_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string req);
        item_t it;
        it.v = v; it.req = req;
        exp_q.push_back(it);
    endtask

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t it;
            logic [7:0] a;
            it = exp_q.pop_front();
            a  = act_q.pop_front();
            chk(it.req, {24'h0, a}, {24'h0, it.v});
        end
    end

    task automatic bus_start();
        m_low = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        m_low = 1'b1; tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        m_low = 1'b0; tick(H);
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        m_low = ~b; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        if (glitch) begin scl_m = 1'b0; tick(1); scl_m = 1'b1; tick(H/2 - 1); end
        else tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; tick(H/2);
        scl_m = 1'b1; tick(H/2);
        b = sda_line; tick(H/2);
        scl_m = 1'b0; tick(H/2);
    endtask

    task automatic put_byte(input logic [7:0] v, input bit glitch, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(input bit ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(~ack, 1'b0);
    endtask

    task automatic i2c_wr(input logic [6:0] a, input logic [7:0] cmd, input int n,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input bit glitch, output logic aack);
        logic ack;
        bus_start();
        put_byte({a, 1'b0}, 1'b0, aack);
        put_byte(cmd, 1'b0, ack);
        if (aack) chk("R10 command ack", {31'h0, ack}, 32'h1);
        if (n > 0) begin
            put_byte(d0, glitch, ack);
            if (aack) chk("R10 data ack", {31'h0, ack}, 32'h1);
        end
        if (n > 1) begin
            put_byte(d1, glitch, ack);
            if (aack) chk("R10 data ack", {31'h0, ack}, 32'h1);
        end
        bus_stop();
    endtask

    task automatic i2c_rd(input logic [7:0] cmd, input int n);
        logic ack;
        logic [7:0] v;
        bus_start();
        put_byte({cur_addr, 1'b0}, 1'b0, ack);
        put_byte(cmd, 1'b0, ack);
        bus_start();
        put_byte({cur_addr, 1'b1}, 1'b0, ack);
        for (int i = 0; i < n; i++) begin
            get_byte(i < n - 1, v);
            act_q.push_back(v);
        end
        tick(4);
        chk("R10 release after NACK", {31'h0, sda_oe}, 32'h0);
        bus_stop();
    endtask

    initial begin
        logic aack;
        tick(5);
        rst_n = 1'b1;
        tick(20);
        // R1 reset state
        chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        chk("R1 pin_o", {16'h0, pin_o}, 32'h0000FFFF);
        chk("R1 int_n", {31'h0, int_n}, 32'h1);
        chk("R1 sda_oe", {31'h0, sda_oe}, 32'h0);
        expect_byte(8'hFF, "R1 out0"); expect_byte(8'hFF, "R1 out1");
        i2c_rd(8'h02, 2);
        expect_byte(8'h00, "R1 pol0"); expect_byte(8'h00, "R1 pol1");
        i2c_rd(8'h04, 2);
        expect_byte(8'hFF, "R1 cfg0"); expect_byte(8'hFF, "R1 cfg1");
        i2c_rd(8'h06, 2);

        // R3 writes with pointer toggle, R4 direction
        i2c_wr(cur_addr, 8'h02, 2, 8'hA5, 8'h3C, 1'b0, aack);
        chk("R10 address ack", {31'h0, aack}, 32'h1);
        i2c_wr(cur_addr, 8'h06, 2, 8'h0F, 8'hF0, 1'b0, aack);
        tick(4);
        chk("R3 R4 pin_o", {16'h0, pin_o}, 32'h00003CA5);
        chk("R4 pin_oe", {16'h0, pin_oe}, 32'h00000FF0);

        // R5 read pointer toggling
        expect_byte(8'hA5, "R5 byte0"); expect_byte(8'h3C, "R5 byte1"); expect_byte(8'hA5, "R5 byte2");
        i2c_rd(8'h02, 3);
        expect_byte(8'hF0, "R5 odd start"); expect_byte(8'h0F, "R5 odd wrap");
        i2c_rd(8'h07, 2);

        // R6 polarity view
        i2c_wr(cur_addr, 8'h04, 2, 8'h03, 8'h80, 1'b0, aack);
        pin_i = 16'hC396;
        tick(20);
        expect_byte(8'h95, "R6 in0"); expect_byte(8'h43, "R6 in1");
        i2c_rd(8'h00, 2);
        tick(4);
        chk("R9 cleared by read", {31'h0, int_n}, 32'h1);

        // R7 writes to input registers ignored
        i2c_wr(cur_addr, 8'h00, 2, 8'h55, 8'hAA, 1'b0, aack);
        expect_byte(8'h95, "R7 in0"); expect_byte(8'h43, "R7 in1");
        i2c_rd(8'h00, 2);
        expect_byte(8'hA5, "R7 out0");
        i2c_rd(8'h02, 1);
        expect_byte(8'h03, "R7 pol0"); expect_byte(8'h80, "R7 pol1");
        i2c_rd(8'h04, 2);
        expect_byte(8'h0F, "R7 cfg0");
        i2c_rd(8'h06, 1);

        // R8 / R9 interrupt
        pin_i = 16'hC397; tick(20);
        chk("R8 input change", {31'h0, int_n}, 32'h0);
        pin_i = 16'hC396; tick(20);
        chk("R9 revert clears", {31'h0, int_n}, 32'h1);
        pin_i = 16'hC397; tick(20);
        chk("R8 change again", {31'h0, int_n}, 32'h0);
        expect_byte(8'h94, "R9 in0 read");
        i2c_rd(8'h00, 1);
        tick(4);
        chk("R9 read clears", {31'h0, int_n}, 32'h1);
        pin_i = 16'hC3B7; tick(20);
        chk("R8 output pin ignored", {31'h0, int_n}, 32'h1);
        pin_i = 16'hD3B7; tick(20);
        chk("R8 port1 change", {31'h0, int_n}, 32'h0);
        expect_byte(8'hB4, "R9 other port read");
        i2c_rd(8'h00, 1);
        tick(4);
        chk("R9 other port no clear", {31'h0, int_n}, 32'h0);
        expect_byte(8'h53, "R9 port1 read");
        i2c_rd(8'h01, 1);
        tick(4);
        chk("R9 port1 clears", {31'h0, int_n}, 32'h1);

        // R2 address match
        i2c_wr(7'h26, 8'h02, 1, 8'h00, 8'h00, 1'b0, aack);
        chk("R2 wrong address nack", {31'h0, aack}, 32'h0);
        tick(4);
        chk("R2 no change", {16'h0, pin_o}, 32'h00003CA5);
        strap = 3'b110; cur_addr = 7'h26; tick(4);
        i2c_wr(cur_addr, 8'h03, 1, 8'h77, 8'h00, 1'b0, aack);
        chk("R2 new strap ack", {31'h0, aack}, 32'h1);
        expect_byte(8'h77, "R2 new strap write");
        i2c_rd(8'h03, 1);

        // R11 SCL glitch rejection
        i2c_wr(cur_addr, 8'h04, 1, 8'h81, 8'h00, 1'b1, aack);
        expect_byte(8'h81, "R11 glitch write");
        i2c_rd(8'h04, 1);

        tick(20);
        if (exp_q.size() != 0 || act_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d left expected %0d left", act_q.size(), exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule